// File: doc/BRIEF.md
# Burst Read Prefetch Target

This block is the read side of a bus target. It serves burst memory reads from a small prefetch buffer, and it fills that buffer from an internal memory port. A master opens or resumes a read with a one-cycle request that carries its master ID and word address. The block answers in the same cycle with accept or retry. After an accept, the block returns one data word on each clock in which it has buffered data. The master marks its final wanted word with `rd_last`.

A new stream fetches a short block of words at the requested address. When the buffer has almost run dry during a transfer, the block fetches the next block of the same stream. Memory latency varies, so the buffer can run empty. If no data phase completes within the allowed window after the previous one, the block drops the transfer with a disconnect. It keeps the stream so that the same master can come back at its next address and continue.

While a fill is in flight, any request that is not that continuation gets retry. A request from a different master when no fill is in flight starts a new stream and throws away the old buffered words.

Top module: `rd_prefetch_tgt`

## Requirements
- R1: During and right after reset, `dat_valid`, `disconnect`, `fill_req` and `req_accept` are all 0.
- R2: A request is accepted as a new stream when no transfer is active, no fill is pending, and the master ID or address differs from the stored stream. In the cycle after the accept, `fill_req` pulses for one cycle with `fill_addr` equal to the requested address.
- R3: Each data phase (`dat_valid` high) returns the word for the stream's next address, and that address then advances by one. Words are served in the order the fill responses delivered them.
- R4: During an active transfer, the block issues a follow-on fill when at most `LOW_WM` words (default 1) remain buffered and no fill is pending. The follow-on fill's `fill_addr` is the previous fill address plus `PF_WORDS` (default 4).
- R5: Once a transfer has completed its first data phase, `disconnect` is raised in the `PHASE_LIMIT`-th consecutive clock (default 8) without a data phase, and not in any earlier clock. The counter restarts at every completed phase. Before the first data phase of a transfer, no disconnect is ever raised.
- R6: A disconnect clock carries no data and ends the transfer. The same master requesting at the stream's next address is accepted, even while a fill is pending. Data then resumes from that address.
- R7: While a fill is pending, a request that is not a matching continuation gets `req_retry` and not `req_accept`. This holds both for a different master and for the same master at a different address.
- R8: A new-stream request discards all buffered words. The first word returned is the one at the new address.
- R9: A data phase that completes with `rd_last` high ends the transfer. No data phase occurs in the following clock.
- R10: A request that arrives while a transfer is active gets neither accept nor retry.
- R11: At most one fill is outstanding. `fill_req` is never raised until all `PF_WORDS` responses of the previous fill have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle read request (open or resume) |
| req_master | input | MW | Requesting master ID |
| req_addr | input | AW | Requested word address |
| req_accept | output | 1 | Request accepted; transfer active from the next clock |
| req_retry | output | 1 | Request refused; try again later |
| rd_last | input | 1 | Master wants no word after the current one |
| dat_valid | output | 1 | Data phase completes this clock |
| dat_data | output | DW | Returned word |
| disconnect | output | 1 | Transfer dropped by the phase-time limit |
| fill_req | output | 1 | One-cycle fill request to memory |
| fill_addr | output | AW | First word address of the fill |
| fill_rsp_valid | input | 1 | One fill word valid this clock |
| fill_rsp_data | input | DW | Fill word |

## Verification
The bench sweeps memory latency from 1 to 12 clocks against burst lengths from 1 to 14 words. Each burst uses a fresh master and address, and each word's expected value is computed arithmetically from its address. Short latencies show that refills arrive in time and no disconnect occurs. Long latencies force repeated disconnect-and-resume cycles, and the bench checks each disconnect against its own count of idle clocks since the last phase. Because every burst changes the master and the address while stale prefetched words remain buffered, the first returned word shows whether the flush took place. A directed burst sends a foreign request during a transfer, then a foreign master and a wrong-address request from the owner while a refill is pending. This tells silent ignore, retry and accepted continuation apart.

// File: rtl/rpf_pkg.sv
// Package: shared types for the burst read prefetch target.
// Assumes: nothing beyond IEEE 1800-2017.
package rpf_pkg;

    // Outcome of a request in the cycle it is presented
    typedef enum logic [1:0] {
        DEC_IDLE  = 2'd0,
        DEC_RETRY = 2'd1,
        DEC_CONT  = 2'd2,
        DEC_NEW   = 2'd3
    } rpf_dec_e;

endpackage

// File: rtl/rpf_buffer.sv
// Module: circular word buffer holding prefetched read data.
// Does: stores pushed words in order, presents the oldest one, tracks fill level.
// Assumes: flush is never raised in the same cycle as push; the caller keeps
// pushes within capacity and pops only when count is non-zero.
module rpf_buffer #(
    parameter int DW    = 32,
    parameter int DEPTH = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] level;

    // Next pointer value with wrap at DEPTH
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write on push
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_data;
        end
    end

    // Pointer and level tracking, cleared by reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign rd_data = store[rd_ptr];
    assign count   = level;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (level < CW'(DEPTH))) else $error("buffer overflow"); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (level != '0)) else $error("buffer underflow"); // R3
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !push) else $error("flush during push"); // R8

endmodule

// File: rtl/rpf_fill_ctrl.sv
// Module: memory fill sequencer.
// Does: issues fixed-size fill requests at a new-stream address or at the next
// unfetched address of the current stream, then counts the responses.
// Assumes: start_new is only raised while no fill is pending; responses arrive
// no earlier than the cycle after fill_req, one word per valid strobe.
module rpf_fill_ctrl #(
    parameter int AW       = 16,
    parameter int PF_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_new,
    input  logic [AW-1:0] new_addr,
    input  logic          refill_want,
    input  logic          rsp_valid,
    output logic          fill_req,
    output logic [AW-1:0] fill_addr,
    output logic          pending
);
    localparam int LW = $clog2(PF_WORDS + 1);

    logic [AW-1:0] fetch_addr;
    logic [LW-1:0] words_left;
    logic          issue;
    logic [AW-1:0] issue_addr;

    // Pick when and where the next fill starts
    always_comb begin
        issue      = start_new || (refill_want && !pending);
        issue_addr = start_new ? new_addr : fetch_addr;
    end

    // Fill issue, address advance and response counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_req   <= 1'b0;
            fill_addr  <= '0;
            fetch_addr <= '0;
            pending    <= 1'b0;
            words_left <= '0;
        end else begin
            fill_req <= issue;
            if (issue) begin
                fill_addr  <= issue_addr;
                fetch_addr <= issue_addr + AW'(PF_WORDS);
                pending    <= 1'b1;
                words_left <= LW'(PF_WORDS);
            end else if (rsp_valid && pending) begin
                words_left <= words_left - 1'b1;
                if (words_left == LW'(1)) pending <= 1'b0;
            end
        end
    end

    AST_ONE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> $rose(pending)) else $error("fill issued while pending"); // R11
    AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(rsp_valid)) else $error("fill ended without data"); // R11
    AST_NEW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_new |-> !pending) else $error("new stream during fill"); // R7
    AST_RSP_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> pending) else $error("stray fill response"); // R11

endmodule

// File: rtl/rpf_phase_timer.sv
// Module: data-phase deadline counter.
// Does: after the first data phase of a transfer, counts clocks without a phase
// and raises disconnect on the LIMIT-th such clock.
// Assumes: the transfer ends in the cycle after disconnect.
module rpf_phase_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic phase_done,
    output logic disc
);
    localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic          first_done;
    logic [TW-1:0] idle_cnt;

    // Track first phase and idle clocks since the last phase
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            first_done <= 1'b0;
            idle_cnt   <= '0;
        end else if (phase_done) begin
            first_done <= 1'b1;
            idle_cnt   <= '0;
        end else if (first_done) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign disc = active && first_done && !phase_done && (idle_cnt == TW'(LIMIT - 1));

    AST_NO_EARLY_DISC: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |=> !disc) else $error("disconnect right after phase"); // R5

endmodule

// File: rtl/rd_prefetch_tgt.sv
// Module: burst read prefetch target (top).
// Does: decides accept/retry for read requests, owns the current stream
// (master and next address), returns buffered words one per clock, and
// ends transfers on last word or on the phase deadline.
// Assumes: a master raises req_valid for one cycle per attempt; fill responses
// deliver words in address order.
module rd_prefetch_tgt #(
    parameter int DW          = 32,
    parameter int AW          = 16,
    parameter int MW          = 3,
    parameter int PF_WORDS    = 4,
    parameter int LOW_WM      = 1,
    parameter int PHASE_LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [MW-1:0] req_master,
    input  logic [AW-1:0] req_addr,
    output logic          req_accept,
    output logic          req_retry,
    input  logic          rd_last,
    output logic          dat_valid,
    output logic [DW-1:0] dat_data,
    output logic          disconnect,
    output logic          fill_req,
    output logic [AW-1:0] fill_addr,
    input  logic          fill_rsp_valid,
    input  logic [DW-1:0] fill_rsp_data
);
    import rpf_pkg::*;

    localparam int DEPTH = PF_WORDS + LOW_WM;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          active;
    logic          stream_valid;
    logic [MW-1:0] stream_master;
    logic [AW-1:0] next_addr;
    logic          stream_match;
    logic          fill_pending;
    logic [CW-1:0] buf_count;
    logic          phase;
    logic          start_new;
    logic          refill_want;
    rpf_dec_e      dec;

    // Classify the presented request
    always_comb begin
        stream_match = stream_valid && (req_master == stream_master) && (req_addr == next_addr);
        if (!req_valid || active)  dec = DEC_IDLE;
        else if (stream_match)     dec = DEC_CONT;
        else if (fill_pending)     dec = DEC_RETRY;
        else                       dec = DEC_NEW;
    end

    // Request answers, data phase and fill triggers
    always_comb begin
        req_accept  = (dec == DEC_CONT) || (dec == DEC_NEW);
        req_retry   = (dec == DEC_RETRY);
        start_new   = (dec == DEC_NEW);
        phase       = active && (buf_count != '0);
        refill_want = active && (buf_count <= CW'(LOW_WM));
    end

    assign dat_valid = phase;

    // Transfer state and stream ownership
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active        <= 1'b0;
            stream_valid  <= 1'b0;
            stream_master <= '0;
            next_addr     <= '0;
        end else begin
            if (req_accept) begin
                active <= 1'b1;
            end else if ((phase && rd_last) || disconnect) begin
                active <= 1'b0;
            end
            if (start_new) begin
                stream_valid  <= 1'b1;
                stream_master <= req_master;
                next_addr     <= req_addr;
            end else if (phase) begin
                next_addr <= next_addr + 1'b1;
            end
        end
    end

    rpf_buffer #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start_new),
        .push      (fill_rsp_valid),
        .push_data (fill_rsp_data),
        .pop       (phase),
        .rd_data   (dat_data),
        .count     (buf_count)
    );

    rpf_fill_ctrl #(
        .AW       (AW),
        .PF_WORDS (PF_WORDS)
    ) u_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_new   (start_new),
        .new_addr    (req_addr),
        .refill_want (refill_want),
        .rsp_valid   (fill_rsp_valid),
        .fill_req    (fill_req),
        .fill_addr   (fill_addr),
        .pending     (fill_pending)
    );

    rpf_phase_timer #(
        .LIMIT (PHASE_LIMIT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .phase_done (phase),
        .disc       (disconnect)
    );

    AST_DISC_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        disconnect |-> !dat_valid) else $error("data on disconnect"); // R6
    AST_DISC_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        disconnect |=> !active) else $error("transfer survives disconnect"); // R6
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && rd_last) |=> !dat_valid) else $error("data after last"); // R9
    AST_ANSWER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_accept && req_retry)) else $error("accept and retry together"); // R7

endmodule

// File: tb/sim_rd_prefetch_tgt.sv
`timescale 1ns/1ps
module sim_rd_prefetch_tgt;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int MW = 3;
    localparam int PF = 4;
    localparam int LW = 1;
    localparam int PH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [MW-1:0] req_master = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_accept;
    logic          req_retry;
    logic          rd_last = 1'b0;
    logic          dat_valid;
    logic [DW-1:0] dat_data;
    logic          disconnect;
    logic          fill_req;
    logic [AW-1:0] fill_addr;
    logic          fill_rsp_valid = 1'b0;
    logic [DW-1:0] fill_rsp_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int n_disc = 0;
    int mem_lat = 1;
    logic [AW-1:0] exp_fetch = '0;

    always #2.5 clk = ~clk;

    rd_prefetch_tgt #(
        .DW(DW), .AW(AW), .MW(MW), .PF_WORDS(PF), .LOW_WM(LW), .PHASE_LIMIT(PH)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_master(req_master), .req_addr(req_addr),
        .req_accept(req_accept), .req_retry(req_retry),
        .rd_last(rd_last), .dat_valid(dat_valid), .dat_data(dat_data),
        .disconnect(disconnect),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data)
    );

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Memory model: fixed-latency fill responder, checks fill addresses and overlap
    logic          mem_busy = 1'b0;
    logic [AW-1:0] mem_ptr = '0;
    int            mem_wait = 0;
    int            mem_left = 0;
    always @(negedge clk) begin
        fill_rsp_valid = 1'b0;
        if (!rst_n) begin
            mem_busy = 1'b0;
        end else begin
            if (mem_busy) begin
                if (mem_wait > 1) begin
                    mem_wait--;
                end else begin
                    fill_rsp_valid = 1'b1;
                    fill_rsp_data  = word_at(mem_ptr);
                    mem_ptr++;
                    mem_left--;
                    if (mem_left == 0) mem_busy = 1'b0;
                end
            end
            if (fill_req) begin
                chk(!mem_busy, "R11 fill overlap", 32'(mem_busy), 32'd0);
                chk(fill_addr == exp_fetch, "R4 fill address", 32'(fill_addr), 32'(exp_fetch));
                exp_fetch = exp_fetch + AW'(PF);
                mem_busy  = 1'b1;
                mem_ptr   = fill_addr;
                mem_wait  = mem_lat;
                mem_left  = PF;
            end
        end
    end

    // One burst of n words; poke adds foreign/ignored/retry requests
    task automatic run_burst(input logic [MW-1:0] m, input logic [AW-1:0] a, input int n, input bit poke);
        logic [AW-1:0] nx = a;
        int  remain = n;
        bit  new_stream = 1'b1;
        bit  poked = 1'b0;
        bit  got_any = 1'b0;
        exp_fetch = a;
        while (remain > 0) begin
            int  gap = 0;
            int  k = 0;
            bit  first = 1'b0;
            bit  in_txn = 1'b1;
            @(negedge clk);
            req_valid = 1'b1; req_master = m; req_addr = nx; rd_last = 1'b0;
            #1;
            chk(req_accept && !req_retry, new_stream ? "R2 new accept" : "R6 resume accept",
                {30'd0, req_accept, req_retry}, 32'd2);
            while (in_txn) begin
                @(negedge clk);
                k++;
                if (poke && k == 2) begin
                    req_valid = 1'b1; req_master = m + 1'b1; req_addr = nx;
                end else begin
                    req_valid = 1'b0;
                end
                rd_last = (remain == 1);
                #1;
                if (new_stream && k == 1)
                    chk(fill_req && fill_addr == a, "R2 first fill", 32'(fill_addr), 32'(a));
                if (poke && k == 2)
                    chk(!req_accept && !req_retry, "R10 busy request",
                        {30'd0, req_accept, req_retry}, 32'd0);
                chk(!(dat_valid && disconnect), "R6 data on disconnect", 32'(disconnect), 32'd0);
                if (dat_valid) begin
                    chk(dat_data == word_at(nx), got_any ? "R3 data" : "R8 fresh stream data",
                        dat_data, word_at(nx));
                    got_any = 1'b1;
                    nx++;
                    remain--;
                    first = 1'b1;
                    gap = 0;
                    if (rd_last) in_txn = 1'b0;
                end else if (disconnect) begin
                    chk(first && gap == PH - 1, "R5 disconnect timing", 32'(gap), 32'(PH - 1));
                    n_disc++;
                    in_txn = 1'b0;
                    if (poke && !poked) begin
                        poked = 1'b1;
                        @(negedge clk);
                        req_valid = 1'b1; req_master = m + 1'b1; req_addr = nx; rd_last = 1'b0;
                        #1;
                        chk(req_retry && !req_accept, "R7 other master retry",
                            {30'd0, req_accept, req_retry}, 32'd1);
                        @(negedge clk);
                        req_master = m; req_addr = nx + 16'h9;
                        #1;
                        chk(req_retry && !req_accept, "R7 wrong address retry",
                            {30'd0, req_accept, req_retry}, 32'd1);
                    end
                end else begin
                    if (first) chk(gap < PH - 1, "R5 missing disconnect", 32'(gap), 32'(PH - 2));
                    gap++;
                end
            end
            new_stream = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0; rd_last = 1'b0;
        #1;
        chk(!dat_valid, "R9 data after last", 32'(dat_valid), 32'd0);
        repeat (24) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Main sequence
    initial begin
        int lens[6] = '{1, 2, 4, 5, 9, 14};
        repeat (4) @(negedge clk);
        #1;
        chk(!dat_valid && !disconnect && !fill_req && !req_accept, "R1 in reset",
            {28'd0, dat_valid, disconnect, fill_req, req_accept}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!dat_valid && !disconnect && !fill_req && !req_accept, "R1 after reset",
            {28'd0, dat_valid, disconnect, fill_req, req_accept}, 32'd0);
        for (int lat = 1; lat <= 12; lat++) begin
            for (int i = 0; i < 6; i++) begin
                mem_lat = lat;
                run_burst(MW'(lat + i), AW'(lat * 256 + i * 32), lens[i], 1'b0);
            end
        end
        mem_lat = 12;
        run_burst(3'd5, 16'h7000, 20, 1'b1);
        mem_lat = 3;
        run_burst(3'd6, 16'h7100, 3, 1'b0);
        chk(n_disc > 0, "R5 disconnects seen", 32'(n_disc), 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule